// File: doc/BRIEF.md
# Programmable DMA Card Cycle Timer

This block times a single DMA write transfer on a PC Card style socket. A transfer starts when a request and its acknowledge are both high while the timer is idle. It then runs through three phases: setup, command and recovery. During setup the block drives the card's address, enable and data lines. During command it asserts the read strobe. Recovery holds the lines for a short interval before the transfer closes. The length of each phase comes from its own programmable count, multiplied by a per-set prescale factor, plus one clock.

The block holds two timer sets, and a select input chooses one of them when each transfer begins. A card can stretch the command phase with its wait input. A terminal-count flag from the system is carried to the card as an output-enable strobe nested inside the command strobe. When recovery ends, a one-clock done pulse is raised. All strobes are active high at this block's ports.

Top module: `dma_cycle_timer`

## Requirements
- R1: After reset all four outputs are low. In both timer sets the setup, command and recovery counts are 1, 6 and 3 and the prescale code is 0, so a transfer takes 2 setup, 7 command and 4 recovery clocks.
- R2: A transfer starts only on a clock edge where the timer is idle and `dreq` and `dack` are both high. `addr_drive` rises in the following cycle. A request without its acknowledge has no effect.
- R3: Each phase lasts P*N+1 clocks, where N is the programmed count and P is the set's prescale. Prescale code 0, 1, 2 or 3 gives P = 1, 16, 256 or 4096.
- R4: A write with `reg_we` high loads the timer set named by `reg_addr[2]`. The field is chosen by `reg_addr[1:0]`: 0 is setup, 1 is command, 2 is recovery, and 3 is prescale, which takes `reg_wdata[1:0]`.
- R5: `addr_drive` is high through all three phases. `rd_strobe` is high only in the command phase, so addressing is always driven for the whole setup phase before the strobe rises.
- R6: While `card_wait` is high in the command phase, `rd_strobe` stays high. It stays high for at least two clocks after `card_wait` is seen low, and the phase ends no earlier than its programmed length.
- R7: If `sys_tc` is high when the transfer starts, `oe_tc` is high from the second command clock through the clock before the last. It never rises in the first command clock and is low in the last one.
- R8: `done` is high for exactly one clock, in the idle cycle after recovery ends. A request seen in that cycle is ignored.
- R9: `tset` is sampled when a transfer starts. Changing it mid-transfer does not change the remaining phase lengths.
- R10: A count of 0 gives a one-clock phase, whatever the prescale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Set (bit 2) and field (bits 1:0) select |
| reg_wdata | input | 8 | Register write data |
| tset | input | 1 | Timer set for the next transfer |
| dreq | input | 1 | DMA request |
| dack | input | 1 | DMA acknowledge |
| card_wait | input | 1 | Card wait, stretches the command phase |
| sys_tc | input | 1 | System terminal count |
| addr_drive | output | 1 | Address, enable and data drive |
| rd_strobe | output | 1 | Command read strobe |
| oe_tc | output | 1 | Card terminal-count output-enable strobe |
| done | output | 1 | End-of-transfer pulse |

## Verification
The hardest case to reach is a wait release that lands close to the natural end of the command count. Here the two-clock minimum and the nested terminal-count strobe interact, and `oe_tc` has to drop one clock before the strobe is released even though that release depends on the wait input. The stimulus reaches this case by tracking the reference model's phase. It raises `card_wait` at chosen offsets into the command phase: early and brief, held well past the count, and one clock before the count runs out, each with terminal count set. A long run with the largest prescale and a zero setup count covers the extremes of the length formula.

// File: rtl/dma_cycle_timer.sv
module dma_cycle_timer #(
  parameter int CNT_W    = 8,
  parameter int SET_W    = 1,
  parameter int PS_SHIFT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic [SET_W+1:0]   reg_addr,
  input  logic [CNT_W-1:0]   reg_wdata,
  input  logic [SET_W-1:0]   tset,
  input  logic               dreq,
  input  logic               dack,
  input  logic               card_wait,
  input  logic               sys_tc,
  output logic               addr_drive,
  output logic               rd_strobe,
  output logic               oe_tc,
  output logic               done
);
  localparam int NSETS = 2 ** SET_W;
  localparam int TW    = CNT_W + 3 * PS_SHIFT;

  typedef enum logic [1:0] {IDLE, SETUP, CMD, REC} ph_t;

  ph_t              ph;
  logic [TW-1:0]    cnt;
  logic [1:0]       pw;
  logic             first, tc_q, done_q;
  logic [SET_W-1:0] set_q;
  logic [CNT_W-1:0] t_setup [NSETS];
  logic [CNT_W-1:0] t_cmd   [NSETS];
  logic [CNT_W-1:0] t_rec   [NSETS];
  logic [1:0]       pre     [NSETS];

  function automatic logic [TW-1:0] span(input logic [CNT_W-1:0] n, input logic [1:0] p);
    return TW'(n) << (int'(p) * PS_SHIFT);
  endfunction

  wire [SET_W-1:0] wsel    = reg_addr[SET_W+1:2];
  wire             start   = (ph == IDLE) && dreq && dack && !done_q;
  wire             cmd_end = (ph == CMD) && (cnt == '0) && !card_wait && (pw == 2'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= IDLE;
      cnt    <= '0;
      pw     <= 2'd0;
      first  <= 1'b0;
      tc_q   <= 1'b0;
      done_q <= 1'b0;
      set_q  <= '0;
      for (int s = 0; s < NSETS; s++) begin
        t_setup[s] <= CNT_W'(1);
        t_cmd[s]   <= CNT_W'(6);
        t_rec[s]   <= CNT_W'(3);
        pre[s]     <= 2'd0;
      end
    end else begin
      done_q <= 1'b0;
      if (reg_we) begin
        case (reg_addr[1:0])
          2'd0:    t_setup[wsel] <= reg_wdata;
          2'd1:    t_cmd[wsel]   <= reg_wdata;
          2'd2:    t_rec[wsel]   <= reg_wdata;
          default: pre[wsel]     <= reg_wdata[1:0];
        endcase
      end
      case (ph)
        IDLE: if (start) begin
          ph    <= SETUP;
          set_q <= tset;
          tc_q  <= sys_tc;
          cnt   <= span(t_setup[tset], pre[tset]);
        end
        SETUP: if (cnt == '0) begin
          ph    <= CMD;
          cnt   <= span(t_cmd[set_q], pre[set_q]);
          first <= 1'b1;
          pw    <= 2'd0;
        end else begin
          cnt <= cnt - 1'b1;
        end
        CMD: begin
          first <= 1'b0;
          if (cnt != '0) cnt <= cnt - 1'b1;
          if (card_wait) pw <= 2'd2;
          else if (pw != 2'd0) pw <= pw - 1'b1;
          if (cmd_end) begin
            ph  <= REC;
            cnt <= span(t_rec[set_q], pre[set_q]);
          end
        end
        default: if (cnt == '0) begin
          ph     <= IDLE;
          done_q <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      endcase
    end
  end

  assign addr_drive = (ph != IDLE);
  assign rd_strobe  = (ph == CMD);
  assign oe_tc      = tc_q && (ph == CMD) && !first && !cmd_end;
  assign done       = done_q;
endmodule

// File: rtl/dma_cycle_timer_chk.sv
module dma_cycle_timer_chk (
  input logic clk,
  input logic rst,
  input logic card_wait,
  input logic addr_drive,
  input logic rd_strobe,
  input logic oe_tc,
  input logic done
);
  // R5
  strobe_addr_chk: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |-> addr_drive);
  // R5
  setup_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_strobe) |-> $past(addr_drive));
  // R7
  tc_nested_chk: assert property (@(posedge clk) disable iff (rst)
    oe_tc |-> rd_strobe);
  // R7
  tc_late_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_tc) |-> $past(rd_strobe));
  // R7
  tc_early_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_strobe) |-> !$past(oe_tc));
  // R6
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (card_wait && rd_strobe) |=> rd_strobe);
  // R6
  wait_tail_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(card_wait) && rd_strobe) |=> rd_strobe);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!addr_drive ##1 !addr_drive));
endmodule

bind dma_cycle_timer dma_cycle_timer_chk u_chk (
  .clk(clk), .rst(rst), .card_wait(card_wait), .addr_drive(addr_drive),
  .rd_strobe(rd_strobe), .oe_tc(oe_tc), .done(done)
);

// File: tb/sim_dma_cycle_timer.sv
module sim_dma_cycle_timer;
  logic clk = 1'b0, rst = 1'b1;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic tset = 1'b0, dreq = 1'b0, dack = 1'b0, card_wait = 1'b0, sys_tc = 1'b0;
  logic addr_drive, rd_strobe, oe_tc, done;

  always #2 clk = ~clk;

  dma_cycle_timer u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .tset(tset), .dreq(dreq), .dack(dack), .card_wait(card_wait), .sys_tc(sys_tc),
    .addr_drive(addr_drive), .rd_strobe(rd_strobe), .oe_tc(oe_tc), .done(done)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit started = 0;
  string cur_req = "R1";

  // reference model: phase 0 idle, 1 setup, 2 command, 3 recovery
  int m_ph = 0, m_rem = 0, m_pw = 0, m_set = 0;
  bit m_first = 0, m_tc = 0, m_done = 0;
  int m_len [2][3];
  int m_pre [2];

  function automatic int plen(int s, int f);
    return m_len[s][f] * (1 << (4 * m_pre[s]));
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    cyc++;
    if (rst) begin
      m_ph = 0; m_rem = 0; m_pw = 0; m_set = 0; m_first = 0; m_tc = 0; m_done = 0;
      for (int s = 0; s < 2; s++) begin
        m_len[s][0] = 1; m_len[s][1] = 6; m_len[s][2] = 3; m_pre[s] = 0;
      end
    end else begin
      bit nd, endc;
      nd = 0;
      case (m_ph)
        0: if (dreq && dack && !m_done) begin
             m_ph = 1; m_set = int'(tset); m_tc = sys_tc; m_rem = plen(m_set, 0);
           end
        1: if (m_rem == 0) begin
             m_ph = 2; m_rem = plen(m_set, 1); m_first = 1; m_pw = 0;
           end else m_rem--;
        2: begin
             endc = (m_rem == 0) && !card_wait && (m_pw == 0);
             m_first = 0;
             if (m_rem > 0) m_rem--;
             if (card_wait) m_pw = 2; else if (m_pw > 0) m_pw--;
             if (endc) begin m_ph = 3; m_rem = plen(m_set, 2); end
           end
        default: if (m_rem == 0) begin m_ph = 0; nd = 1; end else m_rem--;
      endcase
      m_done = nd;
      if (reg_we) begin
        if (reg_addr[1:0] == 2'd3) m_pre[reg_addr[2]] = int'(reg_wdata[1:0]);
        else m_len[reg_addr[2]][reg_addr[1:0]] = int'(reg_wdata);
      end
    end
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected <150000)", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic cmp(string nm, string rq, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s (%s) t=%0t: actual %b expected %b", rq, nm, cur_req, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (started) begin
    bit e_oe;
    e_oe = m_tc && (m_ph == 2) && !m_first && !((m_rem == 0) && !card_wait && (m_pw == 0));
    cmp("addr_drive", "R5", addr_drive, m_ph != 0);
    cmp("rd_strobe", "R6", rd_strobe, m_ph == 2);
    cmp("oe_tc", "R7", oe_tc, e_oe);
    cmp("done", "R8", done, m_done);
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_we = 1'b0;
  endtask

  task automatic go(logic s, logic tc);
    tset = s; sys_tc = tc; dreq = 1'b1; dack = 1'b1;
    tick(1);
    dreq = 1'b0; dack = 1'b0;
  endtask

  task automatic to_cmd();
    while (m_ph != 2) tick(1);
  endtask

  task automatic settle();
    tick(1);
    while (m_ph != 0 || m_done) tick(1);
    tick(2);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    // R1: reset state and default lengths 2/7/4
    tick(3);
    go(0, 0); settle();
    // R7: terminal count nested in the command strobe
    cur_req = "R7";
    go(0, 1); settle();
    // R2: request without acknowledge and vice versa must not start
    cur_req = "R2";
    dreq = 1'b1; tick(5); dreq = 1'b0; dack = 1'b1; tick(5); dack = 1'b0; tick(2);
    // R4 / R3: program set 1, prescale x16 (code 1)
    cur_req = "R3";
    wr(3'b100, 8'd2); wr(3'b101, 8'd3); wr(3'b110, 8'd1); wr(3'b111, 8'd1);
    go(1, 1);
    // R9: change the set select mid-transfer
    tick(3); tset = 1'b0;
    settle();
    // R10: zero setup count with x4096 prescale
    cur_req = "R10";
    wr(3'b000, 8'd0); wr(3'b001, 8'd1); wr(3'b010, 8'd0); wr(3'b011, 8'd3);
    go(0, 1); settle();
    cur_req = "R3";
    wr(3'b011, 8'd2); wr(3'b000, 8'd1); wr(3'b001, 8'd0);
    go(0, 0); settle();
    wr(3'b000, 8'd1); wr(3'b001, 8'd6); wr(3'b010, 8'd3); wr(3'b011, 8'd0);
    // R6: short wait early in command
    cur_req = "R6";
    go(0, 1); to_cmd(); tick(2); card_wait = 1'b1; tick(3); card_wait = 1'b0; settle();
    // R6: wait held past the count
    go(0, 1); to_cmd(); card_wait = 1'b1; tick(12); card_wait = 1'b0; settle();
    // R6: one-clock wait just before the count runs out
    go(0, 1); to_cmd(); tick(5); card_wait = 1'b1; tick(1); card_wait = 1'b0; settle();
    go(0, 1); to_cmd(); tick(6); card_wait = 1'b1; tick(1); card_wait = 1'b0; settle();
    // R8: request held high across back-to-back transfers
    cur_req = "R8";
    dreq = 1'b1; dack = 1'b1; sys_tc = 1'b1;
    tick(40);
    dreq = 1'b0; dack = 1'b0;
    settle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule